// File: doc/BRIEF.md
# Three-Axis Field Sample Register Bank

This block holds the most recent X, Y and Z field samples of a three-axis sensor and presents them, with status, offset, control and identification bytes, through a byte-wide register port. A sample-valid strobe delivers three signed 16-bit samples at once. While correction is enabled, each sample is shifted by twice a user-programmed 15-bit offset before it is stored, and the result saturates at the signed 16-bit limits.

A status byte tracks fresh data and lost data per axis and for the set of axes as a whole. Reading an axis's high byte acknowledges that axis. The register port works like a burst pointer: a load strobe sets the pointer, and each read or write acts on the byte under the pointer and then advances it. A fast-read control bit makes the pointer step over the low bytes of the outputs, so an 8-bit-per-axis burst needs only four reads.

Top module: `sensor_regbank`

## Requirements
- R1: After reset the status byte (0x00), both control bytes (0x10, 0x11), all six offset bytes (0x09..0x0E) and the mode byte (0x08) read 0x00.
- R2: With the correction bit clear (0x11 bit 5 = 0), a stored axis value equals the input sample plus 2 times that axis's offset, clamped to the range -32768..32767. It is read as a high byte then a low byte at 0x01/0x02 (X), 0x03/0x04 (Y) and 0x05/0x06 (Z).
- R3: With 0x11 bit 5 = 1, the input sample is stored unchanged.
- R4: Status bits 0, 1 and 2 (X, Y, Z ready) set when a sample is stored. An axis's bit clears on a read of that axis's high byte. Reads of the status byte or of low bytes leave it unchanged.
- R5: Status bits 4, 5 and 6 (X, Y, Z overwrite) set when a sample is stored while that axis's ready bit is set. They clear on a read of that axis's high byte.
- R6: Status bit 3 reads 1 while any ready bit is set. Status bit 7 sets with any overwrite and clears only once all three high bytes have been read.
- R7: When a sample is stored in the same cycle as a high-byte read of an axis, that axis's ready bit is 1 afterwards and its overwrite bit is 0.
- R8: Each read or write advances the pointer by one. The pointer steps from 0x11 to 0x00. A load strobe sets the pointer to the given address.
- R9: When 0x10 bit 2 is set, the pointer steps from 0x01 to 0x03, from 0x03 to 0x05 and from 0x05 to 0x07, skipping the low bytes.
- R10: Each offset is 15-bit two's complement. Its high byte (0x09, 0x0B, 0x0D) holds offset bits 14..7. Bits 7..1 of its low byte (0x0A, 0x0C, 0x0E) hold offset bits 6..0, and bit 0 of the low byte reads 0.
- R11: 0x07 reads 0xC4 and 0x0F reads the temperature input. The mode byte 0x08 reads 0 when 0x10 bit 0 is 0. When 0x10 bit 0 is 1 it reads 1 if 0x11 bit 5 = 1 and 2 otherwise.
- R12: Writes to 0x00..0x08 and 0x0F are ignored. Addresses 0x12..0x1F read 0x00. 0x11 keeps only bits 7 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Stores the three samples this cycle |
| smp_x | input | 16 | X sample, two's complement |
| smp_y | input | 16 | Y sample, two's complement |
| smp_z | input | 16 | Z sample, two's complement |
| temp_in | input | 8 | Temperature byte shown at 0x0F |
| acc_ld | input | 1 | Loads the pointer from acc_addr |
| acc_addr | input | 5 | Start address for a burst |
| acc_rd | input | 1 | Consumes the byte under the pointer and advances it |
| acc_wr | input | 1 | Writes acc_wdata under the pointer and advances it |
| acc_wdata | input | 8 | Write data |
| rdata | output | 8 | Byte under the pointer (combinational) |

## Verification
The assertions assume that acc_ld is never asserted together with acc_rd or acc_wr. They also assume that a pointer step is judged from the fast-read bit as it stands in that same cycle. The bench keeps to both: it drives each access strobe alone for one cycle from the falling edge, and it changes the control bytes only between bursts. Samples arrive either on their own or in one deliberate cycle that coincides with a high-byte read.

// File: rtl/sensor_regbank_pkg.sv
package sensor_regbank_pkg;
  localparam int AXES   = 3;
  localparam int BYTE_W = 8;
  localparam int SMP_W  = 16;
  localparam int OFS_W  = 15;
  localparam int ADDR_W = 5;
  localparam int LSB_KEEP = OFS_W - BYTE_W;  // offset bits held in low byte

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OUT0 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_OFS0 = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_TEMP = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] A_CTL1 = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_CTL2 = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] A_LAST = A_CTL2;

  localparam logic [BYTE_W-1:0] ID_VAL = 8'hC4;
  localparam int CTL1_ACT  = 0;
  localparam int CTL1_FAST = 2;
  localparam int CTL2_RAW  = 5;
  localparam int CTL2_AUTO = 7;

  // address of the high byte of pair i starting at base
  function automatic logic [ADDR_W-1:0] pair_addr(input logic [ADDR_W-1:0] base,
                                                  input int i);
    return base + ADDR_W'(2 * i);
  endfunction

  // widened sum: sample + 2*offset
  function automatic logic signed [SMP_W:0] ofs_add(input logic [SMP_W-1:0] s,
                                                    input logic [OFS_W-1:0] o);
    logic signed [SMP_W:0] a, b;
    a = {s[SMP_W-1], s};
    b = {{(SMP_W - OFS_W){o[OFS_W-1]}}, o, 1'b0};
    return a + b;
  endfunction

  function automatic logic [SMP_W-1:0] clamp(input logic signed [SMP_W:0] v);
    if (!v[SMP_W] && v[SMP_W-1]) return {1'b0, {(SMP_W-1){1'b1}}};
    if (v[SMP_W] && !v[SMP_W-1]) return {1'b1, {(SMP_W-1){1'b0}}};
    return v[SMP_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p,
                                                 input logic fast);
    if (p == A_LAST) return '0;
    if (fast && p[0] && p < A_ID) return p + ADDR_W'(2);
    return p + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/regbank_corr.sv
module regbank_corr
  import sensor_regbank_pkg::*;
(
  input  logic [SMP_W-1:0] smp,
  input  logic [OFS_W-1:0] ofs,
  input  logic             raw,
  output logic [SMP_W-1:0] res,
  output logic             sat_hi,
  output logic             sat_lo
);
  logic signed [SMP_W:0] sum;

  always_comb begin
    sum    = ofs_add(smp, ofs);
    sat_hi = !raw && !sum[SMP_W] && sum[SMP_W-1];
    sat_lo = !raw && sum[SMP_W] && !sum[SMP_W-1];
    res    = raw ? smp : clamp(sum);
  end
endmodule

// File: rtl/regbank_flags.sv
module regbank_flags
  import sensor_regbank_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            store,
  input  logic [AXES-1:0] rd_clr,
  output logic [AXES-1:0] dr_q,
  output logic [AXES-1:0] ow_q,
  output logic            zyxow_q,
  output logic [AXES-1:0] ow_set
);
  logic [AXES-1:0] dr_n, ow_n;

  always_comb begin
    ow_set = {AXES{store}} & dr_q & ~rd_clr;
    dr_n   = store ? {AXES{1'b1}} : (dr_q & ~rd_clr);
    ow_n   = ow_set | (ow_q & ~rd_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q    <= '0;
      ow_q    <= '0;
      zyxow_q <= 1'b0;
    end else begin
      dr_q <= dr_n;
      ow_q <= ow_n;
      if (|ow_set)        zyxow_q <= 1'b1;
      else if (dr_n == '0) zyxow_q <= 1'b0;
    end
  end
endmodule

// File: rtl/regbank_ptr.sv
module regbank_ptr
  import sensor_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              step,
  input  logic              fast,
  output logic [ADDR_W-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (ld)   ptr_q <= ld_addr;
    else if (step) ptr_q <= ptr_step(ptr_q, fast);
  end
endmodule

// File: rtl/sensor_regbank.sv
module sensor_regbank
  import sensor_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_x,
  input  logic [SMP_W-1:0]  smp_y,
  input  logic [SMP_W-1:0]  smp_z,
  input  logic [BYTE_W-1:0] temp_in,
  input  logic              acc_ld,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [SMP_W-1:0]    smp_in   [AXES];
  logic [SMP_W-1:0]    corr     [AXES];
  logic [SMP_W-1:0]    out_q    [AXES];
  logic [BYTE_W-1:0]   ofs_hi_q [AXES];
  logic [LSB_KEEP-1:0] ofs_lo_q [AXES];
  logic [AXES-1:0]     sat_hi, sat_lo, rd_clr, dr_q, ow_q, ow_set;
  logic                zyxow_q;
  logic [BYTE_W-1:0]   ctl1_q;
  logic                raw_q, auto_q, fast;
  logic [ADDR_W-1:0]   ptr;
  logic [BYTE_W-1:0]   status, mode_val;

  assign smp_in[0] = smp_x;
  assign smp_in[1] = smp_y;
  assign smp_in[2] = smp_z;
  assign fast      = ctl1_q[CTL1_FAST];

  regbank_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .ld(acc_ld), .ld_addr(acc_addr),
    .step(acc_rd | acc_wr), .fast(fast), .ptr_q(ptr)
  );

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    regbank_corr u_corr (
      .smp(smp_in[g]), .ofs({ofs_hi_q[g], ofs_lo_q[g]}), .raw(raw_q),
      .res(corr[g]), .sat_hi(sat_hi[g]), .sat_lo(sat_lo[g])
    );
    assign rd_clr[g] = acc_rd && !acc_ld && (ptr == pair_addr(A_OUT0, g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q[g]    <= '0;
        ofs_hi_q[g] <= '0;
        ofs_lo_q[g] <= '0;
      end else begin
        if (smp_valid) out_q[g] <= corr[g];
        if (acc_wr && !acc_ld && ptr == pair_addr(A_OFS0, g))
          ofs_hi_q[g] <= acc_wdata;
        if (acc_wr && !acc_ld && ptr == pair_addr(A_OFS0, g) + ADDR_W'(1))
          ofs_lo_q[g] <= acc_wdata[BYTE_W-1:1];
      end
    end
  end

  regbank_flags u_flags (
    .clk(clk), .rst_n(rst_n), .store(smp_valid), .rd_clr(rd_clr),
    .dr_q(dr_q), .ow_q(ow_q), .zyxow_q(zyxow_q), .ow_set(ow_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q <= '0;
      raw_q  <= 1'b0;
      auto_q <= 1'b0;
    end else if (acc_wr && !acc_ld) begin
      if (ptr == A_CTL1) ctl1_q <= acc_wdata;
      if (ptr == A_CTL2) begin
        raw_q  <= acc_wdata[CTL2_RAW];
        auto_q <= acc_wdata[CTL2_AUTO];
      end
    end
  end

  always_comb begin
    status   = {zyxow_q, ow_q, |dr_q, dr_q};
    mode_val = !ctl1_q[CTL1_ACT] ? 8'd0 : (raw_q ? 8'd1 : 8'd2);
    rdata    = '0;
    if (ptr == A_STAT) rdata = status;
    if (ptr == A_ID)   rdata = ID_VAL;
    if (ptr == A_MODE) rdata = mode_val;
    if (ptr == A_TEMP) rdata = temp_in;
    if (ptr == A_CTL1) rdata = ctl1_q;
    if (ptr == A_CTL2) begin
      rdata[CTL2_RAW]  = raw_q;
      rdata[CTL2_AUTO] = auto_q;
    end
    for (int i = 0; i < AXES; i++) begin
      if (ptr == pair_addr(A_OUT0, i))                rdata = out_q[i][SMP_W-1:BYTE_W];
      if (ptr == pair_addr(A_OUT0, i) + ADDR_W'(1))   rdata = out_q[i][BYTE_W-1:0];
      if (ptr == pair_addr(A_OFS0, i))                rdata = ofs_hi_q[i];
      if (ptr == pair_addr(A_OFS0, i) + ADDR_W'(1))   rdata = {ofs_lo_q[i], 1'b0};
    end
  end
endmodule

// File: rtl/sensor_regbank_chk.sv
module sensor_regbank_chk
  import sensor_regbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              acc_ld,
  input logic              acc_rd,
  input logic              fast,
  input logic [ADDR_W-1:0] ptr,
  input logic [BYTE_W-1:0] rdata,
  input logic [AXES-1:0]   rd_clr,
  input logic [AXES-1:0]   dr_q,
  input logic [AXES-1:0]   ow_q,
  input logic              zyxow_q,
  input logic [AXES-1:0]   ow_set
);
  // R4
  store_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (dr_q == {AXES{1'b1}}));
  // R4
  msb_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr[0] && !smp_valid) |=> !dr_q[0]);
  // R5
  overwrite_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ow_set[0] |=> (ow_q[0] && zyxow_q));
  // R6
  combined_ow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zyxow_q) |-> (dr_q == '0));
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr[1] && smp_valid) |=> (dr_q[1] && !ow_q[1]));
  // R9
  fast_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_ld && fast && ptr == A_OUT0) |=> (ptr == A_OUT0 + ADDR_W'(2)));
  // R10
  ofs_lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == A_OFS0 + ADDR_W'(1)) |-> !rdata[0]);
endmodule

bind sensor_regbank sensor_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .acc_ld(acc_ld),
  .acc_rd(acc_rd), .fast(fast), .ptr(ptr), .rdata(rdata), .rd_clr(rd_clr),
  .dr_q(dr_q), .ow_q(ow_q), .zyxow_q(zyxow_q), .ow_set(ow_set)
);

// File: tb/tb_sensor_regbank.sv
module tb_sensor_regbank;
  logic        clk = 0, rst_n = 0;
  logic        smp_valid = 0, acc_ld = 0, acc_rd = 0, acc_wr = 0;
  logic [15:0] smp_x = 0, smp_y = 0, smp_z = 0;
  logic [7:0]  temp_in = 8'h19, acc_wdata = 0, rdata;
  logic [4:0]  acc_addr = 0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sensor_regbank dut (.*);

  int smp_tab[8] = '{0, 1, -1, 32767, -32768, 20000, -20000, 300};
  int ofs_tab[6] = '{0, 1, -1, 16383, -16384, 1234};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic ld(input logic [4:0] a);
    acc_ld = 1; acc_addr = a; @(negedge clk); acc_ld = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    v = rdata; acc_rd = 1; @(negedge clk); acc_rd = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    ld(a); acc_wr = 1; acc_wdata = d; @(negedge clk); acc_wr = 0;
  endtask

  task automatic rd_at(input logic [4:0] a, output logic [7:0] v);
    ld(a); rd(v);
  endtask

  task automatic sample(input int x, input int y, input int z);
    smp_x = 16'(x); smp_y = 16'(y); smp_z = 16'(z);
    smp_valid = 1; @(negedge clk); smp_valid = 0;
  endtask

  task automatic set_ofs(input int axis, input int o);
    logic [14:0] ov;
    ov = 15'(o);
    wr(5'(9 + 2 * axis), ov[14:7]);
    wr(5'(10 + 2 * axis), {ov[6:0], 1'b0});
  endtask

  function automatic logic [15:0] expect_val(input int s, input int o, input bit raw);
    int v;
    if (raw) return 16'(s);
    v = s + 2 * o;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return 16'(v);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] e;
    int xs, ys, zs, xo, yo, zo;
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);

    // R1 reset state
    rd_at(5'h00, v); chk("R1 status", v, 8'h00);
    rd_at(5'h10, v); chk("R1 ctl1", v, 8'h00);
    rd_at(5'h11, v); chk("R1 ctl2", v, 8'h00);
    rd_at(5'h08, v); chk("R1 mode", v, 8'h00);
    for (int a = 9; a <= 14; a++) begin rd_at(5'(a), v); chk("R1 offset", v, 8'h00); end

    // R11 id, temperature, mode
    rd_at(5'h07, v); chk("R11 id", v, 8'hC4);
    rd_at(5'h0F, v); chk("R11 temp", v, 8'h19);
    wr(5'h10, 8'h01); wr(5'h11, 8'h20);
    rd_at(5'h08, v); chk("R11 mode raw", v, 8'h01);
    wr(5'h11, 8'h00);
    rd_at(5'h08, v); chk("R11 mode corrected", v, 8'h02);
    wr(5'h10, 8'h00);

    // R12 ignored writes and unmapped reads, ctl2 bit mask
    wr(5'h07, 8'h55); rd_at(5'h07, v); chk("R12 id write", v, 8'hC4);
    wr(5'h00, 8'hFF); rd_at(5'h00, v); chk("R12 status write", v, 8'h00);
    wr(5'h01, 8'h77); rd_at(5'h01, v); chk("R12 out write", v, 8'h00);
    wr(5'h08, 8'h03); rd_at(5'h08, v); chk("R12 mode write", v, 8'h00);
    for (int a = 18; a < 32; a++) begin wr(5'(a), 8'hA5); rd_at(5'(a), v); chk("R12 unmapped", v, 8'h00); end
    wr(5'h11, 8'hFF); rd_at(5'h11, v); chk("R12 ctl2 mask", v, 8'hA0);
    wr(5'h11, 8'h00);

    // R10 offset byte format
    wr(5'h0A, 8'hFF); rd_at(5'h0A, v); chk("R10 lsb bit0", v, 8'hFE);
    wr(5'h0A, 8'h00);

    // R8 burst increment and wrap
    wr(5'h10, 8'h00);
    ld(5'h0F); rd(v); chk("R8 temp", v, 8'h19); rd(v); chk("R8 ctl1", v, 8'h00);
    rd(v); chk("R8 ctl2", v, 8'h00); rd(v); chk("R8 wrap status", v, 8'h00);
    rd(v); chk("R8 after wrap", v, 8'h00);

    // R2 R3 R10 sweep
    for (int j = 0; j < 6; j++) begin
      xo = ofs_tab[j]; yo = ofs_tab[(j + 2) % 6]; zo = ofs_tab[(j + 4) % 6];
      set_ofs(0, xo); set_ofs(1, yo); set_ofs(2, zo);
      ld(5'h09);
      rd(v); e = 16'({15'(xo), 1'b0}); chk("R10 ofs x hi", v, 8'((xo >> 7) & 8'hFF));
      rd(v); chk("R10 ofs x lo", v, {7'(xo), 1'b0});
      for (int r = 0; r < 2; r++) begin
        wr(5'h11, r ? 8'h20 : 8'h00);
        for (int i = 0; i < 8; i++) begin
          xs = smp_tab[i]; ys = smp_tab[(i + 3) % 8]; zs = smp_tab[(i + 5) % 8];
          sample(xs, ys, zs);
          ld(5'h00);
          rd(v); chk("R4 R6 status fresh", v, 8'h0F);
          e = expect_val(xs, xo, r[0]);
          rd(v); chk(r ? "R3 x hi" : "R2 x hi", v, e[15:8]);
          rd(v); chk(r ? "R3 x lo" : "R2 x lo", v, e[7:0]);
          e = expect_val(ys, yo, r[0]);
          rd(v); chk(r ? "R3 y hi" : "R2 y hi", v, e[15:8]);
          rd(v); chk(r ? "R3 y lo" : "R2 y lo", v, e[7:0]);
          e = expect_val(zs, zo, r[0]);
          rd(v); chk(r ? "R3 z hi" : "R2 z hi", v, e[15:8]);
          rd(v); chk(r ? "R3 z lo" : "R2 z lo", v, e[7:0]);
          rd_at(5'h00, v); chk("R4 R6 status drained", v, 8'h00);
        end
      end
    end
    wr(5'h11, 8'h20);

    // R4 low byte and status reads do not clear
    sample(16, 32, 48);
    rd_at(5'h02, v); rd_at(5'h00, v); rd_at(5'h00, v); chk("R4 no clear", v, 8'h0F);

    // R5 R6 overwrite and combined clearing
    sample(17, 33, 49);
    rd_at(5'h00, v); chk("R5 all overwrite", v, 8'hFF);
    rd_at(5'h01, v); chk("R2 latest x", v, 8'h00);
    rd_at(5'h00, v); chk("R5 x acknowledged", v, 8'hEE);
    rd_at(5'h03, v); rd_at(5'h00, v); chk("R6 combined held", v, 8'hCC);
    rd_at(5'h05, v); rd_at(5'h00, v); chk("R6 combined cleared", v, 8'h00);

    // R7 same-cycle store and high-byte read of X
    sample(1, 2, 3);
    ld(5'h01);
    smp_x = 16'h0102; smp_y = 16'h0304; smp_z = 16'h0506;
    smp_valid = 1; acc_rd = 1; @(negedge clk); smp_valid = 0; acc_rd = 0;
    rd_at(5'h00, v); chk("R7 set wins", v, 8'hEF);
    rd_at(5'h01, v); chk("R7 new x stored", v, 8'h01);
    rd_at(5'h03, v); rd_at(5'h05, v);

    // R9 fast read path
    wr(5'h10, 8'h04);
    sample(16'h1122, 16'h3344, 16'h5566);
    ld(5'h00);
    rd(v); chk("R9 status", v, 8'h0F);
    rd(v); chk("R9 x hi", v, 8'h11);
    rd(v); chk("R9 y hi", v, 8'h33);
    rd(v); chk("R9 z hi", v, 8'h55);
    rd(v); chk("R9 id after z", v, 8'hC4);
    rd_at(5'h00, v); chk("R9 drained", v, 8'h00);
    wr(5'h10, 8'h00);
    ld(5'h05); rd(v); rd(v); chk("R8 normal z lo", v, 8'h66);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule